// File: doc/BRIEF.md
# Blit Scale Factor Calculator

This block works out the resampling set-up that a 2D copy engine needs before a job can run. It takes the width and height of the source rectangle, the width and height of the destination rectangle, a two-bit rotation code and a flag that selects the older silicon revision. For each axis it returns a scaling mode and a 16-bit factor, normalised to 2^16, that gives the ratio of the smaller extent to the larger one. It also returns the active width and height fields, each written as the size minus one.

The engine scales first and rotates afterwards. For a quarter or three-quarter turn, the horizontal scale target is therefore the destination height and the vertical target is the destination width. On the older revision, a rotated job also has its source sizes trimmed before any comparison is made. Both axes share one restoring divider, which produces one quotient bit per cycle. The horizontal quotient is computed first and the vertical one second.

A job is launched with a one-cycle `start` while the unit is idle. `busy` stays high until the results are ready. `done` then pulses for one cycle. A zero size, or a trim that would leave nothing, is reported through `err` and no division is performed.

Top module: `blit_scale_calc`

## Requirements
- R1: Each axis reports a mode on a 2-bit output: 0 = none (trimmed source equals its target), 1 = down (source larger), 2 = up (source smaller). The value 3 never appears.
- R2: An axis in mode none reports a factor of zero.
- R3: An axis in mode down reports floor(target * 65536 / source) + 1.
- R4: An axis in mode up reports floor((source - 1) * 65536 / (target - 1)).
- R5: The rotation code is 0 = 0 deg, 1 = 90 deg, 2 = 180 deg and 3 = 270 deg. Codes 1 and 3 make the horizontal target the destination height and the vertical target the destination width. Codes 0 and 2 keep each axis on its own destination size.
- R6: When `legacy` is high and the rotation code is 1 or 3, the source height is reduced by 8 if the destination width equals the source height.
- R7: Under the same condition, the source width is reduced by 16 if it differs from the destination height by less than 16. With `legacy` low or with rotation code 0 or 2, neither size is trimmed.
- R8: `act_w` and `act_h` equal the trimmed source width and height minus one.
- R9: `start` is taken only while `busy` is low. `busy` is high from the cycle after an accepted start until the results are ready. `done` is a single-cycle pulse with `busy` low.
- R10: A `start` while `busy` is high is ignored: the running job finishes with the results of its own inputs.
- R11: If any input size is zero, or a trim would bring a size to zero or below, `done` pulses with `err` high, and both modes, both factors and both active fields are zero. `err` is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a job (taken when idle) |
| legacy | input | 1 | Apply the older-revision size trims |
| rot | input | 2 | Rotation code |
| src_w | input | SW | Source width |
| src_h | input | SW | Source height |
| dst_w | input | SW | Destination width |
| dst_h | input | SW | Destination height |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last job rejected |
| hmode | output | 2 | Horizontal scaling mode |
| vmode | output | 2 | Vertical scaling mode |
| hfac | output | 16 | Horizontal factor |
| vfac | output | 16 | Vertical factor |
| act_w | output | SW | Active width field |
| act_h | output | SW | Active height field |

## Verification
The hardest cases to reach are the older-revision trims. They need a rotated job in which the destination width matches the source height exactly, or in which the source width lies within 16 of the destination height. Both trims are driven at once with hand-picked sizes, and a near-miss case checks that no trim is applied when the conditions do not hold. A trim that would underflow is pushed into the error path. A second start is issued halfway through a division, with different sizes, to show that the running job keeps its own inputs.

// File: rtl/blit_scale_pkg.sv
package blit_scale_pkg;
  localparam int FRAC = 16;

  typedef enum logic [1:0] {
    SCL_NONE = 2'd0,
    SCL_DOWN = 2'd1,
    SCL_UP   = 2'd2
  } scl_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_XDIV = 2'd2,
    ST_YDIV = 2'd3
  } scl_state_e;
endpackage

// File: rtl/scl_axis.sv
module scl_axis
  import blit_scale_pkg::*;
#(
  parameter int SW = 12
) (
  input  logic [SW-1:0] s,
  input  logic [SW-1:0] t,
  output scl_mode_e     mode,
  output logic [SW-1:0] num,
  output logic [SW-1:0] den
);
  always_comb begin
    if (s == t) begin
      mode = SCL_NONE;
      num  = '0;
      den  = SW'(1);
    end else if (s > t) begin
      mode = SCL_DOWN;
      num  = t;
      den  = s;
    end else begin
      mode = SCL_UP;
      num  = s - SW'(1);
      den  = t - SW'(1);
    end
  end
endmodule

// File: rtl/scl_prep.sv
module scl_prep
  import blit_scale_pkg::*;
#(
  parameter int SW = 12
) (
  input  logic [SW-1:0] src_w,
  input  logic [SW-1:0] src_h,
  input  logic [SW-1:0] dst_w,
  input  logic [SW-1:0] dst_h,
  input  logic [1:0]    rot,
  input  logic          legacy,
  output logic [SW-1:0] cor_w,
  output logic [SW-1:0] cor_h,
  output logic          bad,
  output scl_mode_e     h_mode,
  output scl_mode_e     v_mode,
  output logic [SW-1:0] h_num,
  output logic [SW-1:0] h_den,
  output logic [SW-1:0] v_num,
  output logic [SW-1:0] v_den
);
  localparam logic [SW-1:0] H_TRIM = SW'(8);
  localparam logic [SW-1:0] W_TRIM = SW'(16);

  logic          quarter;
  logic          fix_en;
  logic          h_hit;
  logic          w_hit;
  logic [SW-1:0] w_gap;
  logic [SW-1:0] tgt_w;
  logic [SW-1:0] tgt_h;

  assign quarter = rot[0];
  assign fix_en  = legacy & quarter;
  assign w_gap   = (src_w >= dst_h) ? (src_w - dst_h) : (dst_h - src_w);
  assign h_hit   = fix_en && (dst_w == src_h);
  assign w_hit   = fix_en && (w_gap < W_TRIM);
  assign cor_h   = h_hit ? (src_h - H_TRIM) : src_h;
  assign cor_w   = w_hit ? (src_w - W_TRIM) : src_w;
  assign tgt_w   = quarter ? dst_h : dst_w;
  assign tgt_h   = quarter ? dst_w : dst_h;

  assign bad = (src_w == '0) || (src_h == '0) || (dst_w == '0) || (dst_h == '0) ||
               (h_hit && (src_h <= H_TRIM)) || (w_hit && (src_w <= W_TRIM));

  scl_axis #(.SW(SW)) u_hax (.s(cor_w), .t(tgt_w), .mode(h_mode), .num(h_num), .den(h_den));
  scl_axis #(.SW(SW)) u_vax (.s(cor_h), .t(tgt_h), .mode(v_mode), .num(v_num), .den(v_den));
endmodule

// File: rtl/scl_div.sv
module scl_div #(
  parameter int NW = 12,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic [QW-1:0] quo,
  output logic          fin
);
  localparam int CW = $clog2(QW + 1);

  logic [NW-1:0] rem_q, rem_d;
  logic [NW-1:0] den_q, den_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic [NW:0]   trial;

  assign trial = {rem_q, 1'b0};

  always_comb begin
    rem_d = rem_q;
    den_d = den_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (go) begin
      rem_d = num;
      den_d = den;
      quo_d = '0;
      cnt_d = CW'(QW);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = NW'(trial - {1'b0, den_q});
        quo_d = {quo_q[QW-2:0], 1'b1};
      end else begin
        rem_d = trial[NW-1:0];
        quo_d = {quo_q[QW-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      den_q <= den_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;
endmodule

// File: rtl/blit_scale_calc.sv
module blit_scale_calc
  import blit_scale_pkg::*;
#(
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          legacy,
  input  logic [1:0]    rot,
  input  logic [SW-1:0] src_w,
  input  logic [SW-1:0] src_h,
  input  logic [SW-1:0] dst_w,
  input  logic [SW-1:0] dst_h,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    hmode,
  output logic [1:0]    vmode,
  output logic [15:0]   hfac,
  output logic [15:0]   vfac,
  output logic [SW-1:0] act_w,
  output logic [SW-1:0] act_h
);
  localparam int FW = FRAC;

  scl_state_e    st_q, st_d;
  logic [SW-1:0] sw_q, sw_d, sh_q, sh_d, dw_q, dw_d, dh_q, dh_d;
  logic [1:0]    rot_q, rot_d;
  logic          leg_q, leg_d;
  scl_mode_e     hm_q, hm_d, vm_q, vm_d;
  logic [FW-1:0] hf_q, hf_d, vf_q, vf_d;
  logic [SW-1:0] aw_q, aw_d, ah_q, ah_d;
  logic          err_q, err_d, done_q, done_d;

  logic [SW-1:0] cor_w, cor_h, h_num, h_den, v_num, v_den;
  logic          bad;
  scl_mode_e     h_mode, v_mode;
  logic          div_go, div_fin;
  logic [FW-1:0] div_quo;

  scl_prep #(.SW(SW)) u_prep (
    .src_w(sw_q), .src_h(sh_q), .dst_w(dw_q), .dst_h(dh_q), .rot(rot_q), .legacy(leg_q),
    .cor_w(cor_w), .cor_h(cor_h), .bad(bad), .h_mode(h_mode), .v_mode(v_mode),
    .h_num(h_num), .h_den(h_den), .v_num(v_num), .v_den(v_den)
  );

  assign div_go = ((st_q == ST_PREP) && !bad) || ((st_q == ST_XDIV) && div_fin);

  scl_div #(.NW(SW), .QW(FW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .num((st_q == ST_PREP) ? h_num : v_num),
    .den((st_q == ST_PREP) ? h_den : v_den),
    .quo(div_quo), .fin(div_fin)
  );

  function automatic logic [FW-1:0] pick_fac(scl_mode_e m, logic [FW-1:0] q);
    case (m)
      SCL_DOWN: pick_fac = q + FW'(1);
      SCL_UP:   pick_fac = q;
      default:  pick_fac = '0;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;   sw_d = sw_q;  sh_d = sh_q;  dw_d = dw_q;  dh_d = dh_q;
    rot_d = rot_q; leg_d = leg_q; hm_d = hm_q; vm_d = vm_q;
    hf_d = hf_q;   vf_d = vf_q;  aw_d = aw_q;  ah_d = ah_q;
    err_d = err_q; done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        sw_d = src_w; sh_d = src_h; dw_d = dst_w; dh_d = dst_h;
        rot_d = rot;  leg_d = legacy; err_d = 1'b0;
        st_d = ST_PREP;
      end
      ST_PREP: if (bad) begin
        err_d = 1'b1; done_d = 1'b1;
        hm_d = SCL_NONE; vm_d = SCL_NONE;
        hf_d = '0; vf_d = '0; aw_d = '0; ah_d = '0;
        st_d = ST_IDLE;
      end else begin
        hm_d = h_mode; vm_d = v_mode;
        aw_d = cor_w - SW'(1); ah_d = cor_h - SW'(1);
        st_d = ST_XDIV;
      end
      ST_XDIV: if (div_fin) begin
        hf_d = pick_fac(hm_q, div_quo);
        st_d = ST_YDIV;
      end
      default: if (div_fin) begin
        vf_d = pick_fac(vm_q, div_quo);
        done_d = 1'b1;
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0;
      rot_q <= '0; leg_q <= 1'b0; hm_q <= SCL_NONE; vm_q <= SCL_NONE;
      hf_q <= '0; vf_q <= '0; aw_q <= '0; ah_q <= '0;
      err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; sw_q <= sw_d; sh_q <= sh_d; dw_q <= dw_d; dh_q <= dh_d;
      rot_q <= rot_d; leg_q <= leg_d; hm_q <= hm_d; vm_q <= vm_d;
      hf_q <= hf_d; vf_q <= vf_d; aw_q <= aw_d; ah_q <= ah_d;
      err_q <= err_d; done_q <= done_d;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign hmode = hm_q;
  assign vmode = vm_q;
  assign hfac  = hf_q;
  assign vfac  = vf_q;
  assign act_w = aw_q;
  assign act_h = ah_q;
endmodule

// File: rtl/blit_scale_calc_chk.sv
module blit_scale_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [1:0]  hmode,
  input logic [1:0]  vmode,
  input logic [15:0] hfac,
  input logic [15:0] vfac
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) (hmode != 2'd3) && (vmode != 2'd3));
  // R2
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((hmode != 2'd0) || (hfac == 16'd0)) && ((vmode != 2'd0) || (vfac == 16'd0)));
  // R3
  down_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && (hmode == 2'd1)) |-> (hfac != 16'd0));
  // R11
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> done);
endmodule

bind blit_scale_calc blit_scale_calc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .hmode(hmode), .vmode(vmode), .hfac(hfac), .vfac(vfac)
);

// File: tb/blit_scale_calc_tb_top.sv
`timescale 1ns/1ps
module blit_scale_calc_tb_top;
  localparam int SW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, legacy, busy, done, err;
  logic [1:0] rot, hmode, vmode;
  logic [SW-1:0] src_w, src_h, dst_w, dst_h, act_w, act_h;
  logic [15:0] hfac, vfac;

  int checks = 0;
  int errors = 0;
  int e_hm, e_vm, e_hf, e_vf, e_aw, e_ah, e_err;

  blit_scale_calc #(.SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .legacy(legacy), .rot(rot),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .busy(busy), .done(done), .err(err), .hmode(hmode), .vmode(vmode),
    .hfac(hfac), .vfac(vfac), .act_w(act_w), .act_h(act_h)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic axis_ref(input int s, input int t, output int m, output int f);
    if (s == t) begin m = 0; f = 0; end
    else if (s > t) begin m = 1; f = (t * 65536) / s + 1; end
    else begin m = 2; f = ((s - 1) * 65536) / (t - 1); end
  endtask

  task automatic model(input int sw, sh, dw, dh, r, leg);
    bit q, fx, hh, wh;
    int csw, csh, gap;
    q   = (r == 1) || (r == 3);
    fx  = leg && q;
    gap = (sw > dh) ? sw - dh : dh - sw;
    hh  = fx && (dw == sh);
    wh  = fx && (gap < 16);
    csw = wh ? sw - 16 : sw;
    csh = hh ? sh - 8 : sh;
    e_err = (sw == 0 || sh == 0 || dw == 0 || dh == 0 || (hh && sh <= 8) || (wh && sw <= 16)) ? 1 : 0;
    if (e_err == 1) begin
      e_hm = 0; e_vm = 0; e_hf = 0; e_vf = 0; e_aw = 0; e_ah = 0;
    end else begin
      axis_ref(csw, q ? dh : dw, e_hm, e_hf);
      axis_ref(csh, q ? dw : dh, e_vm, e_vf);
      e_aw = csw - 1;
      e_ah = csh - 1;
    end
  endtask

  task automatic launch(input int sw, sh, dw, dh, r, leg);
    @(negedge clk);
    src_w = SW'(sw); src_h = SW'(sh); dst_w = SW'(dw); dst_h = SW'(dh);
    rot = 2'(r); legacy = leg[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk({tag, " R9 done seen"}, int'(done), 1);
  endtask

  task automatic compare(input string tag);
    chk({tag, " R11 err"}, int'(err), e_err);
    chk({tag, " R1 hmode"}, int'(hmode), e_hm);
    chk({tag, " R1 vmode"}, int'(vmode), e_vm);
    chk({tag, " R2/R3/R4 hfac"}, int'(hfac), e_hf);
    chk({tag, " R2/R3/R4 vfac"}, int'(vfac), e_vf);
    chk({tag, " R8 act_w"}, int'(act_w), e_aw);
    chk({tag, " R8 act_h"}, int'(act_h), e_ah);
    chk({tag, " R9 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    chk({tag, " R9 done single pulse"}, int'(done), 0);
  endtask

  task automatic run_job(input string tag, input int sw, sh, dw, dh, r, leg);
    model(sw, sh, dw, dh, r, leg);
    launch(sw, sh, dw, dh, r, leg);
    wait_done(tag);
    compare(tag);
  endtask

  task automatic t_ignored_start();
    model(300, 120, 150, 240, 0, 0);
    launch(300, 120, 150, 240, 0, 0);
    repeat (6) @(negedge clk);
    src_w = 12'd20; src_h = 12'd20; dst_w = 12'd20; dst_h = 12'd20;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 start while busy");
    compare("R10 start while busy");
    chk("R10 no second job", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; legacy = 1'b0; rot = 2'd0;
    src_w = '0; src_h = '0; dst_w = '0; dst_h = '0;
    repeat (4) @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R11 reset err", int'(err), 0);
    chk("R2 reset hfac", int'(hfac), 0);
    rst_n = 1'b1;
    run_job("R2 equal sizes", 100, 50, 100, 50, 0, 0);
    run_job("R3 downscale", 200, 300, 100, 100, 0, 0);
    run_job("R4 upscale", 100, 40, 200, 90, 0, 0);
    run_job("R3 extreme down", 4095, 4095, 1, 2, 0, 0);
    run_job("R4 up from one", 1, 1, 7, 3, 2, 0);
    run_job("R5 rot90 swap", 100, 200, 200, 100, 1, 0);
    run_job("R5 rot270 swap", 64, 80, 160, 32, 3, 0);
    run_job("R5 rot180 no swap", 64, 80, 160, 32, 2, 0);
    run_job("R6 R7 legacy trims", 64, 48, 48, 70, 1, 1);
    run_job("R7 legacy no trim rot0", 64, 48, 48, 70, 0, 1);
    run_job("R7 legacy near miss", 100, 48, 47, 116, 3, 1);
    run_job("R11 zero size", 0, 40, 20, 20, 0, 0);
    run_job("R11 trim underflow", 10, 40, 20, 12, 1, 1);
    run_job("R11 err cleared", 30, 40, 20, 50, 0, 0);
    t_ignored_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule